// File: doc/BRIEF.md
# Per-Channel Threshold Crossing Detector

This block sits behind a multi-channel converter. Conversion results arrive one at a time, each tagged with its channel number. For every channel the block stores the last result it saw. When a new result arrives on a channel that already has a stored result, the block compares both values with the threshold that channel selects, either threshold A or threshold B. If the two values lie on opposite sides of the threshold, the block marks a crossing in a sticky status word and records its direction. Equality counts as being on the upper side.

Software reads the status word and clears individual bits by writing ones to a clear vector. Each channel has an interrupt enable. A single interrupt request is the registered OR of every status bit whose channel is enabled. Because the block watches every result as it is produced, software does not have to find the crossing sample later in a memory buffer.

The parameter `SIGNED_DATA` selects whether results and thresholds are compared as unsigned or as two's-complement numbers.

Top module: `thr_cross_det`

## Requirements
- R1: The first result on a channel after reset only stores the value. It never sets a status bit, whatever its value.
- R2: An upward crossing sets bit 0 of the field for that channel and threshold. An upward crossing means the stored value is below the threshold and the new value is equal to or above it. The field for channel c and threshold t (A=0, B=1) starts at status bit (c*2+t)*2.
- R3: A downward crossing sets bit 1 of that field. A downward crossing means the stored value is equal to or above the threshold and the new value is below it.
- R4: No status bit is set when the stored value and the new value lie on the same side of the threshold. This includes a result equal to the threshold that follows another result equal to it.
- R5: A crossing is judged only between two successive results on the same channel. Results on other channels in between neither disturb nor use that channel's stored value.
- R6: When a channel's select bit is 0, it is compared with threshold A only. When the bit is 1, it is compared with threshold B only. The field of the threshold that is not selected stays unchanged, even if the values cross that threshold.
- R7: Status bits are sticky. A 1 in the clear vector clears the matching bit at the next clock edge. Bits whose clear bit is 0 keep their value.
- R8: If a crossing sets a bit in the same cycle as a clear of that bit, the bit ends up set.
- R9: `irq` goes to 1 one clock after any status bit of an enabled channel is 1. It goes to 0 one clock after no such bit remains. A channel whose enable is 0 never raises it.
- R10: While `rst` is high, the status word and `irq` are cleared at each clock edge, and every channel forgets its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | A result is present this cycle |
| res_chan | input | CHW | Channel of the result |
| res_data | input | DW | Result value |
| thr_a | input | DW | Threshold A |
| thr_b | input | DW | Threshold B |
| thr_sel | input | NCH | Per-channel threshold choice (0 = A, 1 = B) |
| irq_en | input | NCH | Per-channel interrupt enable |
| clr | input | SW | Write-one-to-clear strobe for the status bits |
| sts | output | SW | Sticky crossing status, 4 bits per channel |
| irq | output | 1 | Registered interrupt request |

## Verification
A result presented before a clock edge updates `sts` at that edge. `irq` follows the status and enables one edge later, so a crossing on an enabled channel reaches `irq` two edges after its result is presented. The bench drives every input at the falling edge. It compares `sts` and `irq` with a behavioural model at each later falling edge, and the model advances on the rising edge just as the design does. Each directed check waits a whole number of cycles matching those latencies before it reads a port.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int NUM_THR = 2;
    localparam int NUM_DIR = 2;
    localparam int BITS_PER_CH = NUM_THR * NUM_DIR;

    typedef enum logic {
        THR_A = 1'b0,
        THR_B = 1'b1
    } thr_id_e;

    typedef struct packed {
        logic dn;
        logic up;
    } xdir_t;

    function automatic int sts_index(input int ch, input int thr, input int dir);
        return (ch * NUM_THR + thr) * NUM_DIR + dir;
    endfunction

endpackage

// File: rtl/thr_cmp.sv
module thr_cmp
    import thr_pkg::*;
#(
    parameter int DW          = 12,
    parameter bit SIGNED_DATA = 1'b0
) (
    input  logic [DW-1:0] prev_val,
    input  logic [DW-1:0] cur_val,
    input  logic [DW-1:0] thr_val,
    output xdir_t         dir
);

    logic prev_hi;
    logic cur_hi;

    generate
        if (SIGNED_DATA) begin : g_signed
            assign prev_hi = $signed(prev_val) >= $signed(thr_val);
            assign cur_hi  = $signed(cur_val)  >= $signed(thr_val);
        end else begin : g_unsigned
            assign prev_hi = prev_val >= thr_val;
            assign cur_hi  = cur_val  >= thr_val;
        end
    endgenerate

    always_comb begin
        dir.up = !prev_hi &&  cur_hi;
        dir.dn =  prev_hi && !cur_hi;
    end

endmodule

// File: rtl/thr_hist.sv
module thr_hist #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int CHW = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    res_vld,
    input  logic [CHW-1:0]          res_chan,
    input  logic [DW-1:0]           res_data,
    output logic [NCH-1:0][DW-1:0]  prev_val,
    output logic [NCH-1:0]          seen
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic hit;
            assign hit = res_vld && (int'(res_chan) == c);

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_val[c] <= '0;
                    seen[c]     <= 1'b0;
                end else if (hit) begin
                    prev_val[c] <= res_data;
                    seen[c]     <= 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/thr_status.sv
module thr_status
    import thr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = NCH * BITS_PER_CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [SW-1:0]  set_v,
    input  logic [SW-1:0]  clr,
    input  logic [NCH-1:0] irq_en,
    output logic [SW-1:0]  sts,
    output logic           irq
);

    logic [SW-1:0] en_mask;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_en
            assign en_mask[c*BITS_PER_CH +: BITS_PER_CH] = {BITS_PER_CH{irq_en[c]}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            irq <= 1'b0;
        end else begin
            sts <= (sts & ~clr) | set_v;
            irq <= |(sts & en_mask);
        end
    end

endmodule

// File: rtl/thr_cross_det.sv
module thr_cross_det
    import thr_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int DW           = 12,
    parameter bit SIGNED_DATA  = 1'b0,
    localparam int CHW         = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SW          = NCH * BITS_PER_CH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           res_vld,
    input  logic [CHW-1:0] res_chan,
    input  logic [DW-1:0]  res_data,
    input  logic [DW-1:0]  thr_a,
    input  logic [DW-1:0]  thr_b,
    input  logic [NCH-1:0] thr_sel,
    input  logic [NCH-1:0] irq_en,
    input  logic [SW-1:0]  clr,
    output logic [SW-1:0]  sts,
    output logic           irq
);

    logic [NCH-1:0][DW-1:0] prev_val;
    logic [NCH-1:0]         seen;
    logic                   chan_ok;
    logic [DW-1:0]          prev_cur;
    logic                   seen_cur;
    thr_id_e                thr_cur;
    logic [DW-1:0]          thr_val;
    xdir_t                  dir;
    logic [SW-1:0]          set_v;

    thr_hist #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .res_vld  (res_vld),
        .res_chan (res_chan),
        .res_data (res_data),
        .prev_val (prev_val),
        .seen     (seen)
    );

    always_comb begin
        chan_ok  = int'(res_chan) < NCH;
        prev_cur = '0;
        seen_cur = 1'b0;
        thr_cur  = THR_A;
        if (chan_ok) begin
            prev_cur = prev_val[res_chan];
            seen_cur = seen[res_chan];
            thr_cur  = thr_sel[res_chan] ? THR_B : THR_A;
        end
        thr_val = (thr_cur == THR_B) ? thr_b : thr_a;
    end

    thr_cmp #(.DW(DW), .SIGNED_DATA(SIGNED_DATA)) u_cmp (
        .prev_val (prev_cur),
        .cur_val  (res_data),
        .thr_val  (thr_val),
        .dir      (dir)
    );

    always_comb begin
        set_v = '0;
        if (res_vld && chan_ok && seen_cur) begin
            set_v[sts_index(int'(res_chan), int'(thr_cur), 0)] = dir.up;
            set_v[sts_index(int'(res_chan), int'(thr_cur), 1)] = dir.dn;
        end
    end

    thr_status #(.NCH(NCH), .SW(SW)) u_status (
        .clk    (clk),
        .rst    (rst),
        .set_v  (set_v),
        .clr    (clr),
        .irq_en (irq_en),
        .sts    (sts),
        .irq    (irq)
    );

endmodule

// File: rtl/thr_cross_chk.sv
module thr_cross_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2,
    parameter int SW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           res_vld,
    input logic [CHW-1:0] res_chan,
    input logic [NCH-1:0] irq_en,
    input logic [SW-1:0]  clr,
    input logic [SW-1:0]  sts,
    input logic           irq
);

    localparam int PER_CH = SW / NCH;

    logic [NCH-1:0] seen_c;
    logic [SW-1:0]  en_x;
    logic           first_res;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_x
            assign en_x[c*PER_CH +: PER_CH] = {PER_CH{irq_en[c]}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) seen_c <= '0;
        else if (res_vld && int'(res_chan) < NCH) seen_c[res_chan] <= 1'b1;
    end

    assign first_res = res_vld && (int'(res_chan) < NCH) && !seen_c[res_chan];

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (sts == '0 && !irq));

    // R1
    first_result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        first_res |=> sts == ($past(sts) & ~$past(clr)));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_vld && clr == '0) |=> $stable(sts));

    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        !res_vld |=> (sts & $past(clr)) == '0);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((sts & en_x) != '0) |=> irq);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((sts & en_x) == '0) |=> !irq);

endmodule

bind thr_cross_det thr_cross_chk #(.NCH(NCH), .CHW(CHW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .res_vld  (res_vld),
    .res_chan (res_chan),
    .irq_en   (irq_en),
    .clr      (clr),
    .sts      (sts),
    .irq      (irq)
);

// File: tb/sim_thr_cross_det.sv
`timescale 1ns/1ps
module sim_thr_cross_det;

    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam int CHW = 2;
    localparam int SW  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           res_vld = 1'b0;
    logic [CHW-1:0] res_chan = '0;
    logic [DW-1:0]  res_data = '0;
    logic [DW-1:0]  thr_a = 12'd100;
    logic [DW-1:0]  thr_b = 12'd2000;
    logic [NCH-1:0] thr_sel = '0;
    logic [NCH-1:0] irq_en = '0;
    logic [SW-1:0]  clr = '0;
    logic [SW-1:0]  sts;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    thr_cross_det #(.NCH(NCH), .DW(DW), .SIGNED_DATA(1'b0)) u0 (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_chan(res_chan),
        .res_data(res_data), .thr_a(thr_a), .thr_b(thr_b), .thr_sel(thr_sel),
        .irq_en(irq_en), .clr(clr), .sts(sts), .irq(irq)
    );

    // behavioural reference
    int            m_prev[NCH];
    bit            m_seen[NCH];
    bit [SW-1:0]   m_sts;
    bit            m_irq;

    function automatic int bitpos(int ch, int t, int d);
        return ch * 4 + t * 2 + d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sts = '0;
            m_irq = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                m_prev[i] = 0;
                m_seen[i] = 1'b0;
            end
        end else begin
            bit [SW-1:0] nxt;
            m_irq = 1'b0;
            for (int i = 0; i < SW; i++)
                if (m_sts[i] && irq_en[i / 4]) m_irq = 1'b1;
            nxt = m_sts & ~clr;
            if (res_vld) begin
                int c, t, th, d;
                c  = int'(res_chan);
                t  = thr_sel[c] ? 1 : 0;
                th = t ? int'(thr_b) : int'(thr_a);
                d  = int'(res_data);
                if (m_seen[c]) begin
                    if (m_prev[c] < th && d >= th) nxt[bitpos(c, t, 0)] = 1'b1;
                    if (m_prev[c] >= th && d < th) nxt[bitpos(c, t, 1)] = 1'b1;
                end
                m_prev[c] = d;
                m_seen[c] = 1'b1;
            end
            m_sts = nxt;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (sts !== m_sts) begin
                errors++;
                $display("FAIL R2 R3 R7 model status: actual=%h expected=%h", sts, m_sts);
            end
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R9 model irq: actual=%b expected=%b", irq, m_irq);
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_field(input int lo, input int n, input string req);
        checks++;
        if (((sts >> lo) & ((1 << n) - 1)) != 0) begin
            errors++;
            $display("FAIL %s: actual=%h expected=0 at bit %0d", req, sts, lo);
        end
    endtask

    task automatic send(input int ch, input int val, input logic [SW-1:0] cmask);
        res_vld  = 1'b1;
        res_chan = CHW'(ch);
        res_data = DW'(val);
        clr      = cmask;
        @(negedge clk);
        res_vld = 1'b0;
        clr     = '0;
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(|sts, 1'b0, "R10 status after reset");
        chk(irq, 1'b0, "R10 irq after reset");
        rst = 1'b0;
        live = 1'b1;
        @(negedge clk);

        // R1: first result is only stored
        send(0, 150, '0);
        chk_field(0, 4, "R1 first result");
        // R3: 150 -> 50 below A=100
        send(0, 50, '0);
        chk(sts[bitpos(0, 0, 1)], 1'b1, "R3 downward A ch0");
        // R2: 50 -> 100 equals threshold, inclusive
        send(0, 100, '0);
        chk(sts[bitpos(0, 0, 0)], 1'b1, "R2 upward inclusive ch0");
        // R4: same side results
        send(1, 10, '0);
        send(1, 20, '0);
        send(1, 100, '0);
        send(1, 100, '0);
        send(1, 4000, '0);
        chk(sts[bitpos(1, 0, 0)], 1'b1, "R2 ch1 10..20->100");
        chk(sts[bitpos(1, 0, 1)], 1'b0, "R4 ch1 no downward");
        send(2, 500, '0);
        send(2, 400, '0);
        chk_field(8, 4, "R4 both above");
        // R5: interleaving
        send(2, 10, '0);
        send(3, 200, '0);
        send(2, 300, '0);
        chk(sts[bitpos(2, 0, 0)], 1'b1, "R5 ch2 interleaved up");
        chk_field(12, 4, "R5 ch3 first only");
        // R6: ch3 on threshold B
        thr_sel[3] = 1'b1;
        send(3, 50, '0);
        chk_field(12, 4, "R6 A crossing ignored on B channel");
        send(3, 2500, '0);
        chk(sts[bitpos(3, 1, 0)], 1'b1, "R6 upward B ch3");
        chk(sts[bitpos(3, 0, 0)], 1'b0, "R6 A field untouched");
        // R7: clear one bit only
        clr = SW'(1) << bitpos(0, 0, 1);
        @(negedge clk);
        clr = '0;
        chk(sts[bitpos(0, 0, 1)], 1'b0, "R7 cleared bit");
        chk(sts[bitpos(0, 0, 0)], 1'b1, "R7 other bit kept");
        // R8: set beats clear (ch0 100 -> 20 down)
        send(0, 20, SW'(1) << bitpos(0, 0, 1));
        chk(sts[bitpos(0, 0, 1)], 1'b1, "R8 set wins over clear");
        // R9: disabled -> no irq
        chk(irq, 1'b0, "R9 irq off while disabled");
        irq_en[0] = 1'b1;
        @(negedge clk);
        chk(irq, 1'b1, "R9 irq one cycle after enable");
        clr = SW'(4'hF);
        @(negedge clk);
        clr = '0;
        chk(irq, 1'b1, "R9 irq still from old status");
        @(negedge clk);
        chk(irq, 1'b0, "R9 irq drops after clear");
        irq_en = 4'b0010;
        @(negedge clk);
        chk(irq, 1'b1, "R9 ch1 enabled");
        // R10: reset clears history and status
        rst = 1'b1;
        @(negedge clk);
        live = 1'b0;
        chk(|sts, 1'b0, "R10 status on reset");
        chk(irq, 1'b0, "R10 irq on reset");
        rst = 1'b0;
        live = 1'b1;
        send(2, 4000, '0);
        chk_field(8, 4, "R10 R1 history forgotten");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule